// File: doc/BRIEF.md
# Program/Erase Status Flag Generator

This block decides what a host sees on the data bus when it reads a flash device while the device is busy with an embedded program or erase. It does not return a plain busy bit. It builds a status byte from three flags. The poll bit shows either the inverse of the bit being written or a zero during erase. The toggle bit inverts after every read, so a host can detect activity with two back-to-back reads. The limit bit latches when the operation runs out of time. A ready output is driven alongside the status byte.

The surrounding controller supplies the busy level, the operation kind, the word being written, a time-limit pulse, a read/reset command pulse and a read strobe. Once the operation ends, reads pass straight through to array data without further action. After a time-limit fault, the status view is held until a read/reset command clears it.

Top module: `flash_status_gen`

## Requirements
- R1: `ready_o` is 0 while `busy_i` is 1 or a time-limit fault is latched, and 1 otherwise. After reset it is 1.
- R2: When `ready_o` is 1, `rd_data_o` equals `array_data_i` in the same cycle.
- R3: While busy with a program (`op_erase_i`=0), bit 7 of `rd_data_o` is the inverse of bit 7 of `prog_data_i`.
- R4: While busy with an erase (`op_erase_i`=1), bit 7 of `rd_data_o` is 0.
- R5: In the status view, bit 6 of `rd_data_o` reads 0 on the first read. It inverts in the cycle after each `rd_stb_i` pulse. Strobes given while ready have no effect on it.
- R6: The toggle bit returns to 0 whenever the status view ends. The first read of any later operation therefore shows 0.
- R7: `timeout_i` sampled high while `busy_i` is 1 sets bit 5 of `rd_data_o` from the next cycle on. `timeout_i` while not busy is ignored.
- R8: A latched time-limit fault keeps the status view after `busy_i` falls. The view shows the last captured operation kind and data, with `ready_o`=0, until `reset_cmd_i` is pulsed.
- R9: In the status view, bits 4..0 read 0, and bit 5 reads 0 unless a fault is latched.
- R10: When `busy_i` falls with no fault latched, the output returns to array data in the same cycle, with no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Embedded operation running |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| prog_data_i | input | DATA_W | Word being programmed |
| timeout_i | input | 1 | Operation exceeded its time limit |
| reset_cmd_i | input | 1 | Read/reset command accepted |
| rd_stb_i | input | 1 | One-cycle host read strobe |
| array_data_i | input | DATA_W | Array read data |
| rd_data_o | output | DATA_W | Data or status seen by host |
| ready_o | output | 1 | 1 = idle, 0 = busy |

## Verification
If the toggle flip-flop is stuck or is never cleared, the error shows on bit 6 at the very next read. It also shows on the first read of the following operation, which must read 0. If the fault latch is not sticky, bit 5 drops one cycle after `busy_i` falls, and `ready_o` rises early in that same cycle. A bad capture register shows up only on the held fault view, where bit 7 must still reflect the data written before busy fell.

// File: rtl/flash_sts_pkg.sv
package flash_sts_pkg;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TGL_BIT  = 6;
  localparam int unsigned TMO_BIT  = 5;
  localparam int unsigned MIN_W    = 8;
endpackage

// File: rtl/flash_sts_capture.sv
module flash_sts_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              erase_o,
  output logic [DATA_W-1:0] data_o
);
  logic              erase_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      erase_q <= 1'b0;
      data_q  <= '0;
    end else if (busy_i) begin
      erase_q <= erase_i;
      data_q  <= data_i;
    end
  end

  // live while busy, held copy once busy drops (fault view)
  assign erase_o = busy_i ? erase_i : erase_q;
  assign data_o  = busy_i ? data_i  : data_q;
endmodule

// File: rtl/flash_sts_flags.sv
module flash_sts_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic timeout_i,
  input  logic clr_i,
  input  logic rd_stb_i,
  output logic active_o,
  output logic tgl_o,
  output logic tmo_o
);
  logic tmo_q, tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmo_q <= 1'b0;
    else if (clr_i)             tmo_q <= 1'b0;
    else if (busy_i && timeout_i) tmo_q <= 1'b1;
  end

  assign active_o = busy_i | tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tgl_q <= 1'b0;
    else if (!active_o) tgl_q <= 1'b0;
    else if (rd_stb_i)  tgl_q <= ~tgl_q;
  end

  assign tgl_o = tgl_q;
  assign tmo_o = tmo_q;
endmodule

// File: rtl/flash_sts_mux.sv
module flash_sts_mux
  import flash_sts_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              active_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tgl_i,
  input  logic              tmo_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] out_o
);
  logic [DATA_W-1:0] sts;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign sts[i] = erase_i ? 1'b0 : ~data_i[i];
    end else if (i == TGL_BIT) begin : g_tgl
      assign sts[i] = tgl_i;
    end else if (i == TMO_BIT) begin : g_tmo
      assign sts[i] = tmo_i;
    end else begin : g_zero
      assign sts[i] = 1'b0;
    end
  end

  assign out_o = active_i ? sts : array_i;
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_sts_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              op_erase_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              timeout_i,
  input  logic              reset_cmd_i,
  input  logic              rd_stb_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ready_o
);
  logic              active, tgl, tmo, cap_erase;
  logic [DATA_W-1:0] cap_data;

  initial begin
    if (DATA_W < MIN_W) $error("DATA_W must be at least 8");
  end

  flash_sts_capture #(.DATA_W(DATA_W)) i_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy_i),
    .erase_i (op_erase_i),
    .data_i  (prog_data_i),
    .erase_o (cap_erase),
    .data_o  (cap_data)
  );

  flash_sts_flags i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy_i),
    .timeout_i (timeout_i),
    .clr_i     (reset_cmd_i),
    .rd_stb_i  (rd_stb_i),
    .active_o  (active),
    .tgl_o     (tgl),
    .tmo_o     (tmo)
  );

  flash_sts_mux #(.DATA_W(DATA_W)) i_mux (
    .active_i (active),
    .erase_i  (cap_erase),
    .data_i   (cap_data),
    .tgl_i    (tgl),
    .tmo_i    (tmo),
    .array_i  (array_data_i),
    .out_o    (rd_data_o)
  );

  assign ready_o = ~active;
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk
  import flash_sts_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              op_erase_i,
  input logic [DATA_W-1:0] prog_data_i,
  input logic              reset_cmd_i,
  input logic              rd_stb_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              ready_o
);
  assert_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !ready_o);

  assert_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> rd_data_o == array_data_i);

  assert_prog_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !op_erase_i) |-> rd_data_o[POLL_BIT] != prog_data_i[POLL_BIT]);

  assert_erase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && op_erase_i) |-> !rd_data_o[POLL_BIT]);

  assert_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && rd_stb_i) |=> (ready_o || rd_data_o[TGL_BIT] != $past(rd_data_o[TGL_BIT])));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && rd_data_o[TMO_BIT] && !reset_cmd_i) |=> (!ready_o && rd_data_o[TMO_BIT]));

  assert_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> rd_data_o[TMO_BIT-1:0] == '0);
endmodule

bind flash_status_gen flash_status_gen_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy_i),
  .op_erase_i   (op_erase_i),
  .prog_data_i  (prog_data_i),
  .reset_cmd_i  (reset_cmd_i),
  .rd_stb_i     (rd_stb_i),
  .array_data_i (array_data_i),
  .rd_data_o    (rd_data_o),
  .ready_o      (ready_o)
);

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0, erase = 1'b0, tmo = 1'b0, rcmd = 1'b0, stb = 1'b0;
  logic [7:0] pdata = 8'h00, arr = 8'h00;
  logic [7:0] dout;
  logic       rdy;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  flash_status_gen i_flash_status_gen (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .op_erase_i(erase),
    .prog_data_i(pdata), .timeout_i(tmo), .reset_cmd_i(rcmd), .rd_stb_i(stb),
    .array_data_i(arr), .rd_data_o(dout), .ready_o(rdy)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); stb = 1'b1; #1 v = dout;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic t_reset;
    arr = 8'h5A; #1;
    chk("R1 ready after reset", {7'd0, rdy}, 8'h01);
    chk("R2 passthrough idle", dout, 8'h5A);
  endtask

  task automatic t_program;
    logic [7:0] v;
    @(negedge clk); busy = 1'b1; erase = 1'b0; pdata = 8'hA5; arr = 8'hFF; #1;
    chk("R1 busy ready low", {7'd0, rdy}, 8'h00);
    rd(v); chk("R3 R5 R9 prog read1", v, 8'h00);
    rd(v); chk("R5 prog read2 toggled", v, 8'h40);
    rd(v); chk("R5 prog read3", v, 8'h00);
    @(negedge clk); busy = 1'b0; arr = 8'hA5; #1;
    chk("R10 done passthrough", dout, 8'hA5);
    chk("R1 ready after done", {7'd0, rdy}, 8'h01);
  endtask

  task automatic t_prog_zero_msb;
    logic [7:0] v;
    @(negedge clk); busy = 1'b1; pdata = 8'h3C; #1;
    rd(v); chk("R3 msb clear data", v, 8'h80);
    @(negedge clk); busy = 1'b0;
  endtask

  task automatic t_erase;
    logic [7:0] v;
    @(negedge clk); busy = 1'b1; erase = 1'b1; pdata = 8'h00; #1;
    rd(v); chk("R4 erase read1", v, 8'h00);
    rd(v); chk("R4 R5 erase read2", v, 8'h40);
    @(negedge clk); busy = 1'b0; erase = 1'b0; arr = 8'hFF; #1;
    chk("R10 erase done", dout, 8'hFF);
  endtask

  task automatic t_toggle_clear;
    logic [7:0] v;
    @(negedge clk); busy = 1'b1; pdata = 8'hFF; #1;
    rd(v);
    @(negedge clk); busy = 1'b0; #1;
    rd(v); rd(v); // idle strobes
    chk("R5 idle strobe passthrough", v, arr);
    @(negedge clk); busy = 1'b1; #1;
    rd(v); chk("R6 fresh op toggle zero", v, 8'h00);
    @(negedge clk); busy = 1'b0;
  endtask

  task automatic t_timeout;
    logic [7:0] v;
    @(negedge clk); tmo = 1'b1; #1;
    @(negedge clk); tmo = 1'b0; #1;
    chk("R7 idle timeout ignored", {7'd0, rdy}, 8'h01);
    @(negedge clk); busy = 1'b1; erase = 1'b0; pdata = 8'h80; tmo = 1'b1; #1;
    chk("R9 limit clear before edge", dout, 8'h00);
    @(negedge clk); tmo = 1'b0; #1;
    chk("R7 limit set", dout, 8'h20);
    @(negedge clk); busy = 1'b0; pdata = 8'h00; arr = 8'h11; #1;
    chk("R8 held view", dout, 8'h20);
    chk("R8 ready low held", {7'd0, rdy}, 8'h00);
    rd(v); rd(v); chk("R8 toggles in fault", v, 8'h60);
    @(negedge clk); rcmd = 1'b1;
    @(negedge clk); rcmd = 1'b0; #1;
    chk("R8 cleared passthrough", dout, 8'h11);
    chk("R1 ready after clear", {7'd0, rdy}, 8'h01);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_prog_zero_msb();
        t_erase();
        t_toggle_clear();
        t_timeout();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hang expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule